// File: doc/BRIEF.md
# Oversampling Serial-Sample TDC Channel

This block turns an asynchronous digital hit into fine-grained timestamps. Upstream, several phase-shifted deserializer lanes each sample the hit and deliver a 4-bit slice per system clock. The channel interleaves those slices into one merged sample word, with the earliest sample in bit 0. It finds the first rising and the first falling transition in that word, including a transition across the boundary from the previous clock's last sample. It then appends the fine bin index to an externally supplied coarse clock count.

Results leave the channel as typed records through a small valid/ready FIFO. Each rising edge gives a leading-edge record. Each falling edge gives a trailing-edge record. When the time-over-threshold mode is on, a falling edge that closes a pulse also gives a width record. The lane count is a build-time choice of 2 or 4: more lanes give finer bins at the cost of more sampling resources. When the FIFO has no room, records are discarded and a saturating counter tallies them.

Top module: `tdc_channel`

## Requirements
- R1: Merged sample bit `b*NUM_LANES + l` is bit `b` of lane `l`, where lane `l` occupies `lanes_i[l*4 +: 4]` and lane bit 0 is the earliest sample. The fine index of an edge is its bit position in the merged word.
- R2: A rising edge is the lowest position `i` where the merged bit `i` is 1 and the preceding sample is 0. For `i = 0` the preceding sample is the last merged bit of the previous clock, which is taken as 0 after reset. It yields a record of kind 0 with time `{coarse_i, i}`.
- R3: A falling edge is found the same way for a 1-to-0 change and yields a record of kind 1 with time `{coarse_i, i}`.
- R4: When a rising and a falling edge occur in the same clock, both records are emitted in time order (lower fine index first).
- R5: With `tot_en_i = 1`, a falling edge that follows a recorded rising edge is immediately followed by a record of kind 2. Its time field is the fall time minus the rise time, modulo 2^TIME_W. A falling edge with no pending rise gives no kind-2 record. With `tot_en_i = 0`, no kind-2 record is produced.
- R6: Only the first rising and the first falling edge of each clock are recorded. Later transitions in the same word are ignored.
- R7: While `rec_valid_o` is high and `rec_ready_i` is low, the record held on the outputs does not change. A record is consumed on a clock where both are high.
- R8: Records that exceed the free FIFO space, measured before that clock's pop, are dropped in time order. `ovf_cnt_o` increases by the number dropped and saturates at all ones.
- R9: After reset, `rec_valid_o` is low and `ovf_cnt_o` is zero.
- R10: With an empty FIFO, the first record of a sample word is on the outputs in the clock after the word is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lanes_i | input | NUM_LANES*4 | Per-clock slices from all sampling lanes |
| coarse_i | input | COARSE_W | Coarse clock count for this sample word |
| tot_en_i | input | 1 | Enables pulse-width records |
| rec_ready_i | input | 1 | Consumer accepts the current record |
| rec_valid_o | output | 1 | A record is available |
| rec_kind_o | output | 2 | 0 leading edge, 1 trailing edge, 2 pulse width |
| rec_time_o | output | COARSE_W+clog2(NUM_LANES*4) | Timestamp or width |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped records |

## Verification
The bench targets a falling edge at fine index 0, which is found only across the word boundary. A design that ignored the previous sample would lose that edge entirely. It drives words holding both edges in each order. Wrong ordering would swap the records, and a wrong pending-rise choice would yield a width taken from the wrong rise. A pulse whose rise was superseded inside one word then ends without a width record, which exposes stale pairing state. A two-clock burst into a nearly full FIFO shows whether the surplus is dropped in time order and whether it is counted, and whether held records stay stable under backpressure.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    REC_RISE = 2'd0,
    REC_FALL = 2'd1,
    REC_TOT  = 2'd2
  } rec_kind_e;
endpackage

// File: rtl/tdc_merge.sv
module tdc_merge #(
  parameter int LANES     = 2,
  parameter int LANE_BITS = 4,
  localparam int W = LANES * LANE_BITS
) (
  input  logic [W-1:0] lanes_i,
  output logic [W-1:0] merged_o
);
  for (genvar b = 0; b < LANE_BITS; b++) begin : g_bit
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged_o[b*LANES + l] = lanes_i[l*LANE_BITS + b];
    end
  end
endmodule

// File: rtl/tdc_edge_enc.sv
module tdc_edge_enc #(
  parameter int W      = 8,
  parameter int FINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      sample_i,
  output logic              rise_v_o,
  output logic [FINE_W-1:0] rise_idx_o,
  output logic              fall_v_o,
  output logic [FINE_W-1:0] fall_idx_o
);
  logic          prev_q;
  logic [W:0]    ext;
  logic [W-1:0]  rvec, fvec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sample_i[W-1];
  end

  assign ext  = {sample_i, prev_q};
  assign rvec = ext[W:1] & ~ext[W-1:0];
  assign fvec = ~ext[W:1] & ext[W-1:0];

  // lowest position wins
  always_comb begin
    rise_v_o   = 1'b0;
    rise_idx_o = '0;
    fall_v_o   = 1'b0;
    fall_idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (rvec[i]) begin
        rise_v_o   = 1'b1;
        rise_idx_o = FINE_W'(i);
      end
      if (fvec[i]) begin
        fall_v_o   = 1'b1;
        fall_idx_o = FINE_W'(i);
      end
    end
  end
endmodule

// File: rtl/tdc_out_fifo.sv
module tdc_out_fifo #(
  parameter int DW    = 21,
  parameter int DEPTH = 4,
  parameter int NW    = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     wr_cnt_i,
  input  logic [NW*DW-1:0] wr_data_i,
  input  logic           rd_i,
  output logic           valid_o,
  output logic [DW-1:0]  rd_data_o,
  output logic [CW-1:0]  free_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < NW; k++) begin
      if (32'(wr_cnt_i) > k)
        mem[AW'(32'(wr_ptr_q[AW-1:0]) + k)] <= wr_data_i[k*DW +: DW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + CW'(wr_cnt_i);
      if (rd_i && valid_o) rd_ptr_q <= rd_ptr_q + CW'(1);
    end
  end

  assign valid_o   = (wr_ptr_q != rd_ptr_q);
  assign rd_data_o = mem[rd_ptr_q[AW-1:0]];
  assign free_o    = CW'(DEPTH) - (wr_ptr_q - rd_ptr_q);
endmodule

// File: rtl/tdc_channel.sv
module tdc_channel
  import tdc_pkg::*;
#(
  parameter int NUM_LANES  = 2,
  parameter int LANE_BITS  = 4,
  parameter int COARSE_W   = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int OVF_W      = 8,
  localparam int SMP_W  = NUM_LANES * LANE_BITS,
  localparam int FINE_W = $clog2(SMP_W),
  localparam int TIME_W = COARSE_W + FINE_W,
  localparam int REC_W  = 2 + TIME_W,
  localparam int CW     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SMP_W-1:0]    lanes_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic                tot_en_i,
  input  logic                rec_ready_i,
  output logic                rec_valid_o,
  output logic [1:0]          rec_kind_o,
  output logic [TIME_W-1:0]   rec_time_o,
  output logic [OVF_W-1:0]    ovf_cnt_o
);
  logic [SMP_W-1:0]  merged;
  logic              rise_v, fall_v, fall_first;
  logic [FINE_W-1:0] rise_idx, fall_idx;
  logic [TIME_W-1:0] rise_ts, fall_ts, start_q, tot_val;
  logic              armed_q;
  logic [REC_W-1:0]  slot [3];
  logic [1:0]        n_rec, n_acc, n_drop;
  logic [CW-1:0]     free;
  logic [REC_W-1:0]  rd_data;
  logic [OVF_W-1:0]  ovf_q;
  logic [OVF_W:0]    ovf_sum;

  tdc_merge #(.LANES(NUM_LANES), .LANE_BITS(LANE_BITS)) u_merge (
    .lanes_i  (lanes_i),
    .merged_o (merged)
  );

  tdc_edge_enc #(.W(SMP_W), .FINE_W(FINE_W)) u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (merged),
    .rise_v_o   (rise_v),
    .rise_idx_o (rise_idx),
    .fall_v_o   (fall_v),
    .fall_idx_o (fall_idx)
  );

  assign rise_ts    = {coarse_i, rise_idx};
  assign fall_ts    = {coarse_i, fall_idx};
  assign fall_first = fall_v && (!rise_v || (fall_idx < rise_idx));
  // fall closes the pending rise if it comes first, else the rise in this word
  assign tot_val    = fall_first ? (fall_ts - start_q) : (fall_ts - rise_ts);

  always_comb begin
    for (int k = 0; k < 3; k++) slot[k] = '0;
    n_rec = '0;
    if (rise_v && !fall_first) begin
      slot[n_rec] = {REC_RISE, rise_ts};
      n_rec = n_rec + 2'd1;
    end
    if (fall_v) begin
      slot[n_rec] = {REC_FALL, fall_ts};
      n_rec = n_rec + 2'd1;
      if (tot_en_i && (!fall_first || armed_q)) begin
        slot[n_rec] = {REC_TOT, tot_val};
        n_rec = n_rec + 2'd1;
      end
    end
    if (rise_v && fall_first) begin
      slot[n_rec] = {REC_RISE, rise_ts};
      n_rec = n_rec + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      armed_q <= 1'b0;
    end else if (rise_v) begin
      start_q <= rise_ts;
      armed_q <= !fall_v || fall_first;
    end else if (fall_v) begin
      armed_q <= 1'b0;
    end
  end

  assign n_acc   = (CW'(n_rec) > free) ? free[1:0] : n_rec;
  assign n_drop  = n_rec - n_acc;
  assign ovf_sum = {1'b0, ovf_q} + (OVF_W + 1)'(n_drop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= '0;
    else if (ovf_sum[OVF_W])     ovf_q <= '1;
    else                         ovf_q <= ovf_sum[OVF_W-1:0];
  end

  tdc_out_fifo #(.DW(REC_W), .DEPTH(FIFO_DEPTH), .NW(3)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_cnt_i  (n_acc),
    .wr_data_i ({slot[2], slot[1], slot[0]}),
    .rd_i      (rec_ready_i),
    .valid_o   (rec_valid_o),
    .rd_data_o (rd_data),
    .free_o    (free)
  );

  assign rec_kind_o = rd_data[REC_W-1 -: 2];
  assign rec_time_o = rd_data[TIME_W-1:0];
  assign ovf_cnt_o  = ovf_q;
endmodule

// File: rtl/tdc_channel_chk.sv
module tdc_channel_chk #(
  parameter int TIME_W = 19,
  parameter int OVF_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rec_valid_o,
  input logic              rec_ready_i,
  input logic [1:0]        rec_kind_o,
  input logic [TIME_W-1:0] rec_time_o,
  input logic [OVF_W-1:0]  ovf_cnt_o
);
  AST_KIND_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_kind_o != 2'd3)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=>
      (rec_valid_o && $stable(rec_kind_o) && $stable(rec_time_o))); // R7

  AST_OVF_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o != $past(ovf_cnt_o)) |-> (ovf_cnt_o > $past(ovf_cnt_o))); // R8

  AST_OVF_NEEDS_BACKLOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o != $past(ovf_cnt_o)) |-> $past(rec_valid_o)); // R8
endmodule

bind tdc_channel tdc_channel_chk #(.TIME_W(TIME_W), .OVF_W(OVF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_kind_o  (rec_kind_o),
  .rec_time_o  (rec_time_o),
  .ovf_cnt_o   (ovf_cnt_o)
);

// File: tb/tdc_channel_tb.sv
module tdc_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int L      = 2;
  localparam int W      = L * 4;
  localparam int TIME_W = 19;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [W-1:0]      lanes_i = '0;
  logic [15:0]       coarse_i = '0;
  logic              tot_en_i = 1'b0;
  logic              rec_ready_i = 1'b0;
  logic              rec_valid_o;
  logic [1:0]        rec_kind_o;
  logic [TIME_W-1:0] rec_time_o;
  logic [7:0]        ovf_cnt_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tdc_channel u_dut (
    .clk_i, .rst_ni, .lanes_i, .coarse_i, .tot_en_i, .rec_ready_i,
    .rec_valid_o, .rec_kind_o, .rec_time_o, .ovf_cnt_o
  );

  function automatic logic [TIME_W-1:0] ts(input int c, input int i);
    return {c[15:0], i[2:0]};
  endfunction

  // R1: merged bit b*L+l comes from lane l bit b
  function automatic logic [W-1:0] to_lanes(input logic [W-1:0] w);
    logic [W-1:0] r;
    for (int b = 0; b < 4; b++)
      for (int l = 0; l < L; l++)
        r[l*4 + b] = w[b*L + l];
    return r;
  endfunction

  task automatic drive_lanes(input logic [W-1:0] raw, input int c);
    @(negedge clk_i);
    lanes_i  = raw;
    coarse_i = c[15:0];
    @(posedge clk_i);
    #1 lanes_i = {W{raw[W-1]}};
  endtask

  task automatic drive_word(input logic [W-1:0] w, input int c);
    drive_lanes(to_lanes(w), c);
  endtask

  task automatic expect_rec(input logic [1:0] k, input logic [TIME_W-1:0] t, input string req);
    @(negedge clk_i);
    n_checks++;
    if (!(rec_valid_o === 1'b1 && rec_kind_o === k && rec_time_o === t)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b kind=%0d time=%0h, expected valid=1 kind=%0d time=%0h",
               req, rec_valid_o, rec_kind_o, rec_time_o, k, t);
    end
    rec_ready_i = 1'b1;
    @(posedge clk_i);
    #1 rec_ready_i = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk_i);
    n_checks++;
    if (rec_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: valid=%0b kind=%0d, expected valid=0", req, rec_valid_o, rec_kind_o);
    end
  endtask

  task automatic set_tot(input logic en);
    @(negedge clk_i);
    tot_en_i = en;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    n_checks++;
    if (rec_valid_o !== 1'b0 || ovf_cnt_o !== 8'd0) begin
      n_fail++;
      $display("FAIL R9: valid=%0b ovf=%0d, expected valid=0 ovf=0", rec_valid_o, ovf_cnt_o);
    end
  endtask

  // R2, R3, R10: rise mid-word, fall across the word boundary
  task automatic t_rise_then_fall;
    set_tot(1'b0);
    drive_word(8'hF8, 10);
    expect_rec(2'd0, ts(10, 3), "R2/R10");
    drive_word(8'h00, 11);
    expect_rec(2'd1, ts(11, 0), "R3 boundary");
    expect_empty("R3 single record");
  endtask

  // R1: raw lane slices, lane 1 leading at index 1
  task automatic t_lane_order;
    drive_lanes({4'b1111, 4'b1110}, 20);
    expect_rec(2'd0, ts(20, 1), "R1 rise");
    drive_lanes({4'b0001, 4'b0011}, 21);
    expect_rec(2'd1, ts(21, 3), "R1 fall");
    expect_empty("R1 no extra");
  endtask

  // R4, R5: rise before fall in one word
  task automatic t_both_rise_first;
    set_tot(1'b1);
    drive_word(8'h3C, 30);
    expect_rec(2'd0, ts(30, 2), "R4 first");
    expect_rec(2'd1, ts(30, 6), "R4 second");
    expect_rec(2'd2, 19'd4, "R5 same word");
    expect_empty("R5 end");
  endtask

  // R4, R5: fall before rise, width from the earlier rise
  task automatic t_both_fall_first;
    drive_word(8'hC0, 40);
    expect_rec(2'd0, ts(40, 6), "R2 rise");
    drive_word(8'hF1, 41);
    expect_rec(2'd1, ts(41, 1), "R4 fall first");
    expect_rec(2'd2, 19'd3, "R5 across clocks");
    expect_rec(2'd0, ts(41, 4), "R4 rise second");
    drive_word(8'h00, 42);
    expect_rec(2'd1, ts(42, 0), "R3 close");
    expect_rec(2'd2, 19'd4, "R5 new pulse");
    expect_empty("R5 end");
  endtask

  // R6, R5: second rise in a word ignored, so its fall has no pending rise
  task automatic t_unpaired_fall;
    drive_word(8'hFA, 50);
    expect_rec(2'd0, ts(50, 1), "R6 first rise");
    expect_rec(2'd1, ts(50, 2), "R6 first fall");
    expect_rec(2'd2, 19'd1, "R5 short");
    expect_empty("R6 later rise ignored");
    drive_word(8'h00, 51);
    expect_rec(2'd1, ts(51, 0), "R6 fall");
    expect_empty("R5 no width without pending rise");
  endtask

  task automatic t_tot_off;
    set_tot(1'b0);
    drive_word(8'h3C, 55);
    expect_rec(2'd0, ts(55, 2), "R5 off rise");
    expect_rec(2'd1, ts(55, 6), "R5 off fall");
    expect_empty("R5 disabled");
  endtask

  // R7: record held under backpressure
  task automatic t_backpressure;
    drive_word(8'hF0, 60);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      n_checks++;
      if (!(rec_valid_o === 1'b1 && rec_kind_o === 2'd0 && rec_time_o === ts(60, 4))) begin
        n_fail++;
        $display("FAIL R7: valid=%0b kind=%0d time=%0h, expected valid=1 kind=0 time=%0h",
                 rec_valid_o, rec_kind_o, rec_time_o, ts(60, 4));
      end
    end
    expect_rec(2'd0, ts(60, 4), "R7 pop");
    drive_word(8'h00, 61);
    expect_rec(2'd1, ts(61, 0), "R7 next");
    expect_empty("R7 drained");
  endtask

  // R8: second burst overfills the 4-entry FIFO
  task automatic t_overflow;
    set_tot(1'b1);
    drive_word(8'h3C, 70);
    drive_word(8'h3C, 71);
    @(negedge clk_i);
    n_checks++;
    if (ovf_cnt_o !== 8'd2) begin
      n_fail++;
      $display("FAIL R8: ovf=%0d, expected 2", ovf_cnt_o);
    end
    expect_rec(2'd0, ts(70, 2), "R8 kept 1");
    expect_rec(2'd1, ts(70, 6), "R8 kept 2");
    expect_rec(2'd2, 19'd4, "R8 kept 3");
    expect_rec(2'd0, ts(71, 2), "R8 kept earliest of burst");
    expect_empty("R8 rest dropped");
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_rise_then_fall();
    t_lane_order();
    t_both_rise_first();
    t_both_fall_first();
    t_unpaired_fall();
    t_tot_off();
    t_backpressure();
    t_overflow();
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule